// File: doc/BRIEF.md
# Multi-Bank Memory Address Decoder

This block sits at the front of a memory controller with several programmable banks. Each bank is described by a 17-bit base value, a 17-bit mask, a 3-bit control-machine code, a per-bank bus tag and a valid bit. Two requesters share the decoder: the system bus and the local bus. For each accepted request, the block ANDs the 17 most significant address bits with every bank's mask and compares the result with that bank's base. Among the eligible hits it picks the lowest-numbered bank. It then reports which control machine takes over the access: the SDRAM machine, the general-purpose chip-select machine, or one of three user-programmable machines.

Each bank belongs to either the system bus or the local bus. A system-bus hit on a local-bus bank is handed to the local bus, and the block flags this. A local-bus request only sees local-bus banks. Once a bank wins, its bank index and machine code are held until the cycle-done input releases them. A request that matches nothing produces a one-cycle miss pulse and takes no ownership.

Top module: `bank_addr_decoder`

## Requirements
- R1: A bank matches when its valid bit is set and (address AND mask) equals its base, compared over all 17 bits. A bank whose valid bit is clear never matches.
- R2: When several eligible banks match, the one with the lowest index wins.
- R3: Machine codes are 0 = SDRAM machine, 1 = general-purpose chip-select machine, and 2, 3, 4 = user-programmable machines A, B, C. `own_mach` reports the winning bank's code. A bank whose code is reserved (5 to 7) never matches.
- R4: A bank whose code is 2, 3 or 4 takes its bus tag from `upm_bus_local` bit 0, 1 or 2 respectively. Any other bank takes it from its own `cfg_bus_local` bit. In both cases 1 means local bus.
- R5: When a system-bus request wins a local-bus bank, the block takes ownership with `xfer_local` = 1 and `own_is_loc` = 0. A system-bus win on a system-bus bank gives `xfer_local` = 0.
- R6: A local-bus request considers only local-bus banks. Its win sets `own_is_loc` = 1. If no local-bus bank matches, it is a miss with `miss_loc` = 1, even if a system-bus bank matches.
- R7: A request strobe seen at a clock edge while the block is idle yields its result in the outputs right after that edge.
- R8: While `own_valid` is high, bank, machine and flags stay unchanged, and request strobes are ignored. A `cycle_done` at an edge clears `own_valid` after that edge.
- R9: A request with no eligible match raises `miss` for exactly one cycle, leaves `own_valid` low, and the block accepts a new request at the very next edge.
- R10: If both strobes are high in the same idle cycle, the system request is served first. The local request is held pending and served at the first idle edge that has no new system strobe. Only one local request is held, and other local strobes arriving meanwhile are ignored.
- R11: After reset all outputs are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | NB | Per-bank valid bit |
| cfg_base | input | NB*17 | Bank i base at bits [i*17 +: 17] |
| cfg_mask | input | NB*17 | Bank i mask at bits [i*17 +: 17] |
| cfg_mach | input | NB*3 | Bank i machine code at bits [i*3 +: 3] |
| cfg_bus_local | input | NB | Bus tag for non-UPM banks, 1 = local |
| upm_bus_local | input | 3 | Bus tag of UPM A, B, C, 1 = local |
| sys_req | input | 1 | System-bus request strobe |
| sys_addr | input | 17 | System-bus upper address bits, MSB first |
| loc_req | input | 1 | Local-bus request strobe |
| loc_addr | input | 17 | Local-bus upper address bits, MSB first |
| cycle_done | input | 1 | Ends the owned access |
| own_valid | output | 1 | A machine owns an access |
| own_bank | output | clog2(NB) | Winning bank index |
| own_mach | output | 3 | Winning machine code |
| own_is_loc | output | 1 | Owned access came from the local bus |
| xfer_local | output | 1 | System access forwarded to the local bus |
| miss | output | 1 | One-cycle no-match pulse |
| miss_loc | output | 1 | The missed request came from the local bus |

## Verification
The bench targets several overlap and routing cases. Overlapping banks must resolve to the lower index, or the wrong machine would get the access. A masked-off lower bank that is invalid or has a reserved code must be skipped, not allowed to win. A user-programmable bank must take its bus tag from the machine's own bit rather than the per-bank bit, or forwarding flips. A local request whose only match is a system-bus bank must miss. The bench also drives simultaneous requests and strobes during a held access: a faulty design would lose the pending local request, serve it out of turn, or let a new strobe overwrite the held bank.

// File: rtl/bank_dec_pkg.sv
// Shared constants and machine encodings for the bank address decoder.
// Assumes a 3-bit machine code; codes above UPM C are reserved.
package bank_dec_pkg;
    localparam int unsigned MACH_W = 3;
    localparam int unsigned UPM_N  = 3;

    typedef enum logic [MACH_W-1:0] {
        MACH_SDRAM = 3'd0,
        MACH_GPCM  = 3'd1,
        MACH_UPMA  = 3'd2,
        MACH_UPMB  = 3'd3,
        MACH_UPMC  = 3'd4
    } mach_e;

    // True when the code names a real machine.
    function automatic logic mach_legal(input logic [MACH_W-1:0] code);
        return code <= MACH_UPMC;
    endfunction
endpackage

// File: rtl/bank_match_array.sv
// Per-bank comparator array. For one address, it produces a hit vector
// (valid, legal machine code, masked compare) and the effective bus tag
// of every bank. Assumes upm_bus_local is indexed by (code - 2).
module bank_match_array
    import bank_dec_pkg::*;
#(
    parameter int unsigned NB = 12,
    parameter int unsigned AW = 17
) (
    input  logic [AW-1:0]        addr,
    input  logic [NB-1:0]        cfg_valid,
    input  logic [NB*AW-1:0]     cfg_base,
    input  logic [NB*AW-1:0]     cfg_mask,
    input  logic [NB*MACH_W-1:0] cfg_mach,
    input  logic [NB-1:0]        cfg_bus_local,
    input  logic [UPM_N-1:0]     upm_bus_local,
    output logic [NB-1:0]        hit_vec,
    output logic [NB-1:0]        local_vec
);
    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        logic [AW-1:0]     base_i;
        logic [AW-1:0]     mask_i;
        logic [MACH_W-1:0] mach_i;

        assign base_i = cfg_base[gi*AW +: AW];
        assign mask_i = cfg_mask[gi*AW +: AW];
        assign mach_i = cfg_mach[gi*MACH_W +: MACH_W];

        // Masked compare qualified by the valid bit and a legal code.
        always_comb begin
            hit_vec[gi] = cfg_valid[gi] && mach_legal(mach_i)
                          && ((addr & mask_i) == base_i);
        end

        // Bus tag: UPM banks follow their machine's bit, others their own.
        always_comb begin
            case (mach_i)
                MACH_UPMA: local_vec[gi] = upm_bus_local[0];
                MACH_UPMB: local_vec[gi] = upm_bus_local[1];
                MACH_UPMC: local_vec[gi] = upm_bus_local[2];
                default:   local_vec[gi] = cfg_bus_local[gi];
            endcase
        end
    end
endmodule

// File: rtl/bank_prio_pick.sv
// Fixed-priority picker: returns the lowest set index of the eligible
// vector. Assumes BW is wide enough to hold NB-1.
module bank_prio_pick #(
    parameter int unsigned NB = 12,
    parameter int unsigned BW = 4
) (
    input  logic [NB-1:0] elig,
    output logic          found,
    output logic [BW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = BW'(i);
            end
        end
    end
endmodule

// File: rtl/bank_own_ctl.sv
// Request arbitration and ownership register. Picks the request to decode,
// holds one pending local request, registers the decode result and holds
// ownership until cycle_done. Assumes the decode inputs are combinational
// from sel_addr and sel_loc in the same cycle.
module bank_own_ctl
    import bank_dec_pkg::*;
#(
    parameter int unsigned AW = 17,
    parameter int unsigned BW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_req,
    input  logic [AW-1:0]     sys_addr,
    input  logic              loc_req,
    input  logic [AW-1:0]     loc_addr,
    input  logic              cycle_done,
    input  logic              found,
    input  logic [BW-1:0]     win_idx,
    input  logic [MACH_W-1:0] win_mach,
    input  logic              win_local,
    output logic [AW-1:0]     sel_addr,
    output logic              sel_loc,
    output logic              take,
    output logic              own_valid,
    output logic [BW-1:0]     own_bank,
    output logic [MACH_W-1:0] own_mach,
    output logic              own_is_loc,
    output logic              xfer_local,
    output logic              miss,
    output logic              miss_loc
);
    logic          busy;
    logic          pend;
    logic [AW-1:0] pend_addr;
    logic          take_sys;
    logic          take_pend;
    logic          take_loc;

    // Choose which request is decoded this cycle: system, pending, then local.
    always_comb begin
        take_sys  = !busy && sys_req;
        take_pend = !busy && !sys_req && pend;
        take_loc  = !busy && !sys_req && !pend && loc_req;
        take      = take_sys || take_pend || take_loc;
        sel_loc   = take_pend || take_loc;
        if (take_pend)     sel_addr = pend_addr;
        else if (take_loc) sel_addr = loc_addr;
        else               sel_addr = sys_addr;
    end

    // Ownership, result and miss registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            own_bank   <= '0;
            own_mach   <= '0;
            own_is_loc <= 1'b0;
            xfer_local <= 1'b0;
            miss       <= 1'b0;
            miss_loc   <= 1'b0;
        end else begin
            miss     <= 1'b0;
            miss_loc <= 1'b0;
            if (busy) begin
                if (cycle_done) begin
                    busy       <= 1'b0;
                    own_bank   <= '0;
                    own_mach   <= '0;
                    own_is_loc <= 1'b0;
                    xfer_local <= 1'b0;
                end
            end else if (take) begin
                if (found) begin
                    busy       <= 1'b1;
                    own_bank   <= win_idx;
                    own_mach   <= win_mach;
                    own_is_loc <= sel_loc;
                    xfer_local <= !sel_loc && win_local;
                end else begin
                    miss     <= 1'b1;
                    miss_loc <= sel_loc;
                end
            end
        end
    end

    // Single-entry store for a local request that lost to a system request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_addr <= '0;
        end else if (take_pend) begin
            pend <= 1'b0;
        end else if (take_sys && loc_req && !pend) begin
            pend      <= 1'b1;
            pend_addr <= loc_addr;
        end
    end

    assign own_valid = busy;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cycle_done |=> busy && $stable(own_bank) && $stable(own_mach)
                                && $stable(xfer_local) && $stable(own_is_loc));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cycle_done |=> !busy);
    assert_miss_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !busy);
    assert_xfer_sys_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_local |-> busy && !own_is_loc);
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && sys_req |=> busy || miss);
    assert_pend_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !sys_req && pend |=> (busy && own_is_loc) || (miss && miss_loc));
endmodule

// File: rtl/bank_addr_decoder.sv
// Top of the multi-bank address decoder. Wires the arbitration/ownership
// controller to the comparator array and the priority picker. Local-bus
// requests are masked down to local-bus banks before the pick.
// Assumes configuration inputs are static while an access is owned.
module bank_addr_decoder
    import bank_dec_pkg::*;
#(
    parameter int unsigned NB = 12,
    parameter int unsigned AW = 17,
    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB-1:0]        cfg_valid,
    input  logic [NB*AW-1:0]     cfg_base,
    input  logic [NB*AW-1:0]     cfg_mask,
    input  logic [NB*MACH_W-1:0] cfg_mach,
    input  logic [NB-1:0]        cfg_bus_local,
    input  logic [UPM_N-1:0]     upm_bus_local,
    input  logic                 sys_req,
    input  logic [AW-1:0]        sys_addr,
    input  logic                 loc_req,
    input  logic [AW-1:0]        loc_addr,
    input  logic                 cycle_done,
    output logic                 own_valid,
    output logic [BW-1:0]        own_bank,
    output logic [MACH_W-1:0]    own_mach,
    output logic                 own_is_loc,
    output logic                 xfer_local,
    output logic                 miss,
    output logic                 miss_loc
);
    logic [AW-1:0]     sel_addr;
    logic              sel_loc;
    logic              take;
    logic [NB-1:0]     hit_vec;
    logic [NB-1:0]     local_vec;
    logic [NB-1:0]     elig;
    logic              found;
    logic [BW-1:0]     win_idx;
    logic [MACH_W-1:0] mach_arr [NB];
    logic              win_local;
    logic [MACH_W-1:0] win_mach;

    bank_match_array #(.NB(NB), .AW(AW)) u_match (
        .addr          (sel_addr),
        .cfg_valid     (cfg_valid),
        .cfg_base      (cfg_base),
        .cfg_mask      (cfg_mask),
        .cfg_mach      (cfg_mach),
        .cfg_bus_local (cfg_bus_local),
        .upm_bus_local (upm_bus_local),
        .hit_vec       (hit_vec),
        .local_vec     (local_vec)
    );

    // Local requests may only land on local-bus banks.
    always_comb begin
        elig = sel_loc ? (hit_vec & local_vec) : hit_vec;
    end

    bank_prio_pick #(.NB(NB), .BW(BW)) u_pick (
        .elig  (elig),
        .found (found),
        .idx   (win_idx)
    );

    for (genvar gi = 0; gi < NB; gi++) begin : g_mach
        assign mach_arr[gi] = cfg_mach[gi*MACH_W +: MACH_W];
    end

    // Winner's machine code and bus tag.
    always_comb begin
        win_mach  = mach_arr[win_idx];
        win_local = local_vec[win_idx];
    end

    bank_own_ctl #(.AW(AW), .BW(BW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_req    (sys_req),
        .sys_addr   (sys_addr),
        .loc_req    (loc_req),
        .loc_addr   (loc_addr),
        .cycle_done (cycle_done),
        .found      (found),
        .win_idx    (win_idx),
        .win_mach   (win_mach),
        .win_local  (win_local),
        .sel_addr   (sel_addr),
        .sel_loc    (sel_loc),
        .take       (take),
        .own_valid  (own_valid),
        .own_bank   (own_bank),
        .own_mach   (own_mach),
        .own_is_loc (own_is_loc),
        .xfer_local (xfer_local),
        .miss       (miss),
        .miss_loc   (miss_loc)
    );

    assert_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> hit_vec[win_idx]
                  && ((elig & ((NB'(1) << win_idx) - NB'(1))) == '0));
    assert_loc_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take && sel_loc && found |-> local_vec[win_idx]);
    assert_legal_mach_R3: assert property (@(posedge clk) disable iff (!rst_n)
        own_valid |-> mach_legal(own_mach));
endmodule

// File: tb/bank_addr_decoder_test.sv
`timescale 1ns/1ps
module bank_addr_decoder_test;
    localparam int NB = 12;
    localparam int AW = 17;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0]    cfg_valid = '0;
    logic [NB*AW-1:0] cfg_base = '0;
    logic [NB*AW-1:0] cfg_mask = '0;
    logic [NB*3-1:0]  cfg_mach = '0;
    logic [NB-1:0]    cfg_bus_local = '0;
    logic [2:0]       upm_bus_local = '0;
    logic             sys_req = 1'b0;
    logic [AW-1:0]    sys_addr = '0;
    logic             loc_req = 1'b0;
    logic [AW-1:0]    loc_addr = '0;
    logic             cycle_done = 1'b0;
    logic             own_valid;
    logic [BW-1:0]    own_bank;
    logic [2:0]       own_mach;
    logic             own_is_loc;
    logic             xfer_local;
    logic             miss;
    logic             miss_loc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [AW-1:0] t_base [NB];
    logic [AW-1:0] t_mask [NB];
    logic [2:0]    t_mach [NB];
    logic          t_valid [NB];
    logic          t_bloc [NB];

    bank_addr_decoder #(.NB(NB), .AW(AW)) uut (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic apply_cfg();
        for (int i = 0; i < NB; i++) begin
            cfg_base[i*AW +: AW] = t_base[i];
            cfg_mask[i*AW +: AW] = t_mask[i];
            cfg_mach[i*3 +: 3]   = t_mach[i];
            cfg_valid[i]         = t_valid[i];
            cfg_bus_local[i]     = t_bloc[i];
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < NB; i++) begin
            t_base[i] = '0; t_mask[i] = '1; t_mach[i] = 3'd1;
            t_valid[i] = 1'b0; t_bloc[i] = 1'b0;
        end
        upm_bus_local = '0;
        apply_cfg();
    endtask

    // Reference decode from the requirements.
    function automatic void model(input logic [AW-1:0] a, input bit is_loc,
                                  output bit f, output int idx,
                                  output logic [2:0] m, output bit x);
        bit lb;
        f = 0; idx = 0; m = '0; x = 0;
        for (int i = 0; i < NB; i++) begin
            if (!f && t_valid[i] && t_mach[i] <= 3'd4
                && ((a & t_mask[i]) == t_base[i])) begin
                lb = (t_mach[i] >= 3'd2) ? upm_bus_local[t_mach[i] - 3'd2] : t_bloc[i];
                if (!is_loc || lb) begin
                    f = 1; idx = i; m = t_mach[i]; x = !is_loc && lb;
                end
            end
        end
    endfunction

    // Compare the outputs with one expected decode.
    task automatic expect_result(input string req, input logic [AW-1:0] a, input bit is_loc);
        bit f; int idx; logic [2:0] m; bit x;
        model(a, is_loc, f, idx, m, x);
        check(req, "own_valid", 32'(own_valid), 32'(f));
        check(req, "miss", 32'(miss), 32'(!f));
        if (f) begin
            check(req, "own_bank", 32'(own_bank), 32'(idx));
            check(req, "own_mach", 32'(own_mach), 32'(m));
            check(req, "xfer_local", 32'(xfer_local), 32'(x));
            check(req, "own_is_loc", 32'(own_is_loc), 32'(is_loc));
        end else begin
            check(req, "miss_loc", 32'(miss_loc), 32'(is_loc));
        end
    endtask

    // One request pulse; the result is sampled on the next falling edge.
    task automatic one_req(input string req, input bit is_loc, input logic [AW-1:0] a);
        if (is_loc) begin loc_req = 1; loc_addr = a; end
        else begin sys_req = 1; sys_addr = a; end
        @(negedge clk);
        sys_req = 0; loc_req = 0;
        expect_result(req, a, is_loc);
    endtask

    // End the owned access if one is held and check the release.
    task automatic release_own(input bit verify);
        if (own_valid) begin
            cycle_done = 1;
            @(negedge clk);
            cycle_done = 0;
            if (verify) check("R8", "own_valid after done", 32'(own_valid), 32'd0);
        end else begin
            @(negedge clk);
        end
    endtask

    task automatic rand_cfg();
        for (int i = 0; i < NB; i++) begin
            t_mask[i]  = AW'($urandom) | 17'h1C000;
            t_base[i]  = AW'($urandom) & t_mask[i];
            if ($urandom_range(0, 7) == 0) t_base[i] = t_base[i] ^ 17'h10000;
            t_mach[i]  = 3'($urandom_range(0, 5));
            t_valid[i] = ($urandom_range(0, 5) != 0);
            t_bloc[i]  = 1'($urandom);
        end
        upm_bus_local = 3'($urandom);
        apply_cfg();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'd4711));
        clear_cfg();
        repeat (3) @(negedge clk);
        check("R11", "own_valid", 32'(own_valid), 32'd0);
        check("R11", "miss", 32'(miss), 32'd0);
        check("R11", "bank/mach", {own_bank, own_mach}, '0);
        check("R11", "flags", {xfer_local, own_is_loc, miss_loc}, '0);
        rst_n = 1;
        @(negedge clk);
        check("R11", "no pending after reset", 32'(own_valid | miss), 32'd0);

        // R2: overlapping banks 3 and 7, lower index wins.
        t_mask[3] = 17'h1F000; t_base[3] = 17'h05000; t_mach[3] = 3'd0; t_valid[3] = 1;
        t_mask[7] = 17'h1F000; t_base[7] = 17'h05000; t_mach[7] = 3'd3; t_valid[7] = 1;
        apply_cfg();
        one_req("R2", 0, 17'h05123);
        check("R2", "lowest bank", 32'(own_bank), 32'd3);
        release_own(1);
        // R1: invalid bank 3 is skipped.
        t_valid[3] = 0; apply_cfg();
        one_req("R1", 0, 17'h05123);
        check("R1", "skip invalid", 32'(own_bank), 32'd7);
        check("R3", "UPM B code", 32'(own_mach), 32'd3);
        release_own(1);
        // R1: mask compare, a cleared mask bit ignores the address bit.
        one_req("R1", 0, 17'h05FFF);
        release_own(1);
        one_req("R1", 0, 17'h15000);
        check("R9", "mismatch misses", 32'(miss), 32'd1);
        @(negedge clk);
        check("R9", "miss is one cycle", 32'(miss), 32'd0);
        check("R9", "no ownership", 32'(own_valid), 32'd0);
        // R3: reserved code never matches.
        t_mach[7] = 3'd5; apply_cfg();
        one_req("R3", 0, 17'h05123);
        check("R3", "reserved code miss", 32'(miss), 32'd1);
        @(negedge clk);
        // R4/R5: UPM B bank uses upm_bus_local[1]; per-bank tag says system.
        t_mach[7] = 3'd3; t_bloc[7] = 0; upm_bus_local = 3'b010; apply_cfg();
        one_req("R5", 0, 17'h05123);
        check("R4", "UPM tag used", 32'(xfer_local), 32'd1);
        release_own(1);
        one_req("R6", 1, 17'h05123);
        check("R6", "local owns", 32'(own_is_loc), 32'd1);
        release_own(1);
        // R6: local request over a system-bus bank misses.
        upm_bus_local = 3'b000; t_bloc[7] = 1; apply_cfg();
        one_req("R6", 1, 17'h05123);
        check("R6", "miss_loc", 32'(miss_loc), 32'd1);
        @(negedge clk);
        // R4: GPCM bank 2 tagged local, overlapping bank 7.
        t_mask[2] = 17'h1F000; t_base[2] = 17'h05000; t_mach[2] = 3'd1;
        t_valid[2] = 1; t_bloc[2] = 1; apply_cfg();
        one_req("R4", 0, 17'h05001);
        check("R5", "forward via bank tag", 32'(xfer_local), 32'd1);
        release_own(1);

        // R10: simultaneous requests; system first, local pending.
        sys_req = 1; sys_addr = 17'h05100; loc_req = 1; loc_addr = 17'h05200;
        @(negedge clk);
        sys_req = 0; loc_req = 0;
        expect_result("R10", 17'h05100, 0);
        // R8: strobes while owned are ignored.
        sys_req = 1; sys_addr = 17'h00000; loc_req = 1; loc_addr = 17'h00000;
        @(negedge clk);
        sys_req = 0; loc_req = 0;
        check("R8", "bank held", 32'(own_bank), 32'd2);
        check("R8", "still owned", 32'(own_valid), 32'd1);
        release_own(1);
        @(negedge clk);
        expect_result("R10", 17'h05200, 1);
        release_own(1);
        @(negedge clk);
        check("R10", "only one pending", 32'(own_valid | miss), 32'd0);

        // R10: pending served right after a system miss.
        sys_req = 1; sys_addr = 17'h1FFFF; loc_req = 1; loc_addr = 17'h05300;
        @(negedge clk);
        sys_req = 0; loc_req = 0;
        check("R10", "system miss first", 32'(miss), 32'd1);
        @(negedge clk);
        expect_result("R10", 17'h05300, 1);
        release_own(1);

        // Random configurations and addresses.
        for (int c = 0; c < 25; c++) begin
            rand_cfg();
            for (int k = 0; k < 16; k++) begin
                int b;
                bit il;
                b = $urandom_range(0, NB - 1);
                a = (t_base[b] & t_mask[b]) | (AW'($urandom) & ~t_mask[b]);
                if ($urandom_range(0, 4) == 0) a = AW'($urandom);
                il = 1'($urandom);
                one_req(il ? "R6" : "R5", il, a);
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    if (own_valid) check("R8", "held mach", 32'(own_valid), 32'd1);
                end
                release_own(0);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule